// File: doc/BRIEF.md
# Five-over-three resampler output pacer

This block paces the output side of a fixed-ratio interpolator that makes five output samples from every three input samples. Upstream logic offers samples on a stream slave port with valid, ready and data. The block keeps one sample in a holding register and issues it on the stream master port one or two times, together with a polyphase index. A downstream multiply-accumulate stage uses that index to pick its coefficient set. Over every three inputs the outputs per input follow the pattern two, two, one, and the index runs 0 to 4 before it wraps.

Output pacing comes from a configured input period, given in clock cycles. The block divides this period by the largest number of outputs any one input can produce, which is two, and rounds down. The result is the minimum number of cycles between two outputs. The block therefore consumes input faster than the nominal rate. When upstream delivers at exactly the nominal period, the outputs bunch at the minimum spacing and then wait for the next sample, so the average output period comes out fractional.

A generate option places a small input FIFO in front of the holding register. The FIFO takes one sample per clock until it is full, while the pacer drains it at its own rate. Without the FIFO, ready is driven straight from the pacer's demand.

Top module: `frac_interp_sched`

## Requirements
- R1: Output j after reset carries phase index j mod 5. Its data is input number 3*(j div 5) + k, where k is 0, 0, 1, 1, 2 for phases 0 to 4, so each group of three inputs gives 2, 2 and 1 outputs.
- R2: Let S be max(1, floor(P/2)), where P is the configured period. Two outputs are never fewer than S cycles apart. While input is always available, consecutive outputs are exactly S cycles apart.
- R3: When upstream offers one input every P cycles, output j+5 comes exactly 3*P cycles after output j. With P=4 this is 12 cycles per five outputs; with P=3 it is 9 cycles.
- R4: Without the FIFO, ready rises whenever the holding register is empty or its last output is being issued. With valid held high, outputs therefore come back to back at spacing S.
- R5: With the FIFO (default depth 4), a stalled pacer lets the block accept one input per clock until depth+1 inputs are taken, one held plus four queued. Ready then stays low.
- R6: If no input is available when an output slot arrives, nothing is emitted, and the phase resumes where it stopped.
- R7: Synchronous active-high reset clears the master valid and returns the phase to 0. After reset, ready is high in the FIFO variant.
- R8: The period input is captured only while reset is high. Changing it later does not change the output spacing.
- R9: A period of 0 or 1 is treated as giving spacing S = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also captures cfg_in_period |
| cfg_in_period | input | PERIOD_W | Nominal input period in clock cycles |
| s_tvalid | input | 1 | Upstream sample valid |
| s_tready | output | 1 | Block can take a sample |
| s_tdata | input | DATA_W | Upstream sample |
| m_tvalid | output | 1 | Output sample valid, one cycle per output |
| m_tdata | output | DATA_W | Held input sample being issued |
| m_phase | output | PH_W | Polyphase index 0 to 4 |

## Verification
The bench targets the points where the phase sequence meets input stalls. A design that skipped or repeated a phase while starved, or that dropped the held sample early, would show a mismatch in phase or data against the 2-2-1 mapping. It drives periods that leave a remainder and periods below 2. A design that rounded the spacing up, or let it fall to zero, would produce a spacing or a five-output span that differs from S or from 3P. It also fills the FIFO behind a slow pacer, changes the period after reset, and resets in the middle of a group. Those tests catch, in turn: an off-by-one full flag, a period that is read all the time instead of only at reset, and a phase that survives reset.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

   // Largest number of outputs a single input can produce for an UP/DN rate change.
   function automatic int outs_worst(input int up, input int dn);
      return (up + dn - 1) / dn;
   endfunction

   // True when output phase p is the final output produced from its input sample.
   function automatic bit ends_input(input int p, input int up, input int dn);
      return (((p + 1) * dn) / up) != ((p * dn) / up);
   endfunction

endpackage

// File: rtl/fsr_input_fifo.sv
module fsr_input_fifo #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head_data,
   output logic              empty,
   output logic              full
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("fsr_input_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] store [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic [AW:0]       fill;
   logic              do_push, do_pop;

   assign empty     = (fill == '0);
   assign full      = (fill == (AW+1)'(DEPTH));
   assign do_push   = push & ~full;
   assign do_pop    = pop & ~empty;
   assign head_data = store[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) store[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

   // R5: the pacer never pulls from an empty queue, and the fill never passes DEPTH
   a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
   a_r5_fill_bound:   assert property (@(posedge clk) disable iff (rst) fill <= (AW+1)'(DEPTH));

endmodule

// File: rtl/fsr_spacing_timer.sv
module fsr_spacing_timer #(
   parameter int PERIOD_W = 8,
   parameter int WORST    = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [PERIOD_W-1:0] cfg_period,
   input  logic                fire,
   output logic                slot,
   output logic [PERIOD_W-1:0] spacing
);
   localparam logic [PERIOD_W-1:0] WORST_V = PERIOD_W'(WORST);

   if (WORST < 1) begin : g_bad_worst
      $error("fsr_spacing_timer: WORST must be at least 1");
   end

   logic [PERIOD_W-1:0] period_q, quot, wait_q;

   // Period is a static setting: captured only during reset (R8)
   always_ff @(posedge clk) begin
      if (rst) period_q <= cfg_period;
   end

   assign quot    = period_q / WORST_V;
   assign spacing = (quot == '0) ? PERIOD_W'(1) : quot;   // R9 clamp
   assign slot    = (wait_q == '0);

   always_ff @(posedge clk) begin
      if (rst)                wait_q <= '0;
      else if (fire)          wait_q <= spacing - 1'b1;
      else if (wait_q != '0)  wait_q <= wait_q - 1'b1;
   end

   // R2: a fire is only ever requested in an open slot
   a_r2_fire_in_slot: assert property (@(posedge clk) disable iff (rst) fire |-> slot);

endmodule

// File: rtl/fsr_phase_seq.sv
module fsr_phase_seq #(
   parameter int DATA_W = 16,
   parameter int UP     = 5,
   parameter int DN     = 3,
   parameter int PH_W   = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   output logic              src_ready,
   input  logic              slot,
   output logic              emit,
   output logic [DATA_W-1:0] hold_data,
   output logic [PH_W-1:0]   phase
);
   if (UP <= DN) begin : g_bad_ratio
      $error("fsr_phase_seq: UP must exceed DN for interpolation");
   end
   if ((1 << PH_W) < UP) begin : g_bad_phw
      $error("fsr_phase_seq: PH_W too narrow for UP phases");
   end

   logic [UP-1:0]   last_mask;
   logic            hold_v, last_now, take;
   logic [PH_W-1:0] phase_nxt;

   for (genvar g = 0; g < UP; g++) begin : g_last
      assign last_mask[g] = fsr_pkg::ends_input(g, UP, DN);
   end

   assign last_now  = last_mask[phase];
   assign emit      = hold_v & slot;
   // Refill in the same cycle as the last output of the held sample
   assign src_ready = ~hold_v | (emit & last_now);
   assign take      = src_valid & src_ready;
   assign phase_nxt = (phase == PH_W'(UP-1)) ? '0 : phase + 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_v <= 1'b0;
         phase  <= '0;
      end else begin
         if (emit) phase <= phase_nxt;
         if (take)                  hold_v <= 1'b1;
         else if (emit && last_now) hold_v <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (take) hold_data <= src_data;
   end

   // R6: a sample is never replaced while it still owes outputs
   a_r6_no_early_replace: assert property (@(posedge clk) disable iff (rst)
      (hold_v && !(emit && last_now)) |-> !take);

endmodule

// File: rtl/frac_interp_sched.sv
module frac_interp_sched #(
   parameter int DATA_W     = 16,
   parameter int PERIOD_W   = 8,
   parameter int UP         = 5,
   parameter int DN         = 3,
   parameter bit USE_FIFO   = 1'b1,
   parameter int FIFO_DEPTH = 4,
   parameter int PH_W       = $clog2(UP)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [PERIOD_W-1:0] cfg_in_period,
   input  logic                s_tvalid,
   output logic                s_tready,
   input  logic [DATA_W-1:0]   s_tdata,
   output logic                m_tvalid,
   output logic [DATA_W-1:0]   m_tdata,
   output logic [PH_W-1:0]     m_phase
);
   localparam int WORST = fsr_pkg::outs_worst(UP, DN);

   if (DATA_W < 1 || PERIOD_W < 2) begin : g_bad_widths
      $error("frac_interp_sched: DATA_W >= 1 and PERIOD_W >= 2 required");
   end

   logic                src_valid, src_ready, slot, emit;
   logic [DATA_W-1:0]   src_data, hold_data;
   logic [PH_W-1:0]     phase;
   logic [PERIOD_W-1:0] spacing;

   if (USE_FIFO) begin : g_fifo
      logic fifo_empty, fifo_full;
      fsr_input_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
         .clk       (clk),
         .rst       (rst),
         .push      (s_tvalid),
         .push_data (s_tdata),
         .pop       (src_ready & ~fifo_empty),
         .head_data (src_data),
         .empty     (fifo_empty),
         .full      (fifo_full)
      );
      assign src_valid = ~fifo_empty;
      assign s_tready  = ~fifo_full;
   end else begin : g_direct
      assign src_valid = s_tvalid;
      assign src_data  = s_tdata;
      assign s_tready  = src_ready;
   end

   fsr_spacing_timer #(.PERIOD_W(PERIOD_W), .WORST(WORST)) u_timer (
      .clk        (clk),
      .rst        (rst),
      .cfg_period (cfg_in_period),
      .fire       (emit),
      .slot       (slot),
      .spacing    (spacing)
   );

   fsr_phase_seq #(.DATA_W(DATA_W), .UP(UP), .DN(DN), .PH_W(PH_W)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .src_valid (src_valid),
      .src_data  (src_data),
      .src_ready (src_ready),
      .slot      (slot),
      .emit      (emit),
      .hold_data (hold_data),
      .phase     (phase)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         m_tvalid <= 1'b0;
         m_phase  <= '0;
      end else begin
         m_tvalid <= emit;
         if (emit) m_phase <= phase;
      end
   end

   always_ff @(posedge clk) begin
      if (emit) m_tdata <= hold_data;
   end

   // ---- observation state for port-level properties ----
   logic                seen_q;
   logic [PH_W-1:0]     last_ph_q;
   logic [PERIOD_W:0]   since_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_q    <= 1'b0;
         last_ph_q <= '0;
         since_q   <= '0;
      end else begin
         if (m_tvalid) begin
            seen_q    <= 1'b1;
            last_ph_q <= m_phase;
            since_q   <= (PERIOD_W+1)'(1);
         end else if (since_q != '1) begin
            since_q <= since_q + 1'b1;
         end
      end
   end

   // R7: nothing leaves the block in the cycle after reset
   a_r7_reset_quiet: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !m_tvalid);
   // R1: the index stays inside 0..UP-1 and steps by one, wrapping, between outputs
   a_r1_phase_range: assert property (@(posedge clk) disable iff (rst)
      m_tvalid |-> (m_phase < PH_W'(UP)));
   a_r1_phase_step: assert property (@(posedge clk) disable iff (rst)
      (m_tvalid && seen_q) |->
         (m_phase == ((last_ph_q == PH_W'(UP-1)) ? '0 : last_ph_q + 1'b1)));
   // R2: consecutive outputs at least the configured spacing apart
   a_r2_min_spacing: assert property (@(posedge clk) disable iff (rst)
      (m_tvalid && seen_q) |-> (since_q >= {1'b0, spacing}));

endmodule

// File: tb/tb_frac_interp_sched.sv
module tb_frac_interp_sched;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  cfg_period = 8'd4;
   logic        s_tvalid = 1'b0;
   logic        s_tready;
   logic [15:0] s_tdata = '0;
   logic        m_tvalid;
   logic [15:0] m_tdata;
   logic [2:0]  m_phase;

   logic        nf_valid = 1'b0;
   logic        nf_ready;
   logic        nf_mvalid;
   logic [15:0] nf_mdata;
   logic [2:0]  nf_phase;

   always #2 clk = ~clk;   // 250 MHz

   frac_interp_sched dut (
      .clk(clk), .rst(rst), .cfg_in_period(cfg_period),
      .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
      .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_phase(m_phase));

   frac_interp_sched #(.USE_FIFO(1'b0)) dut_nf (
      .clk(clk), .rst(rst), .cfg_in_period(cfg_period),
      .s_tvalid(nf_valid), .s_tready(nf_ready), .s_tdata(16'h00AA),
      .m_tvalid(nf_mvalid), .m_tdata(nf_mdata), .m_phase(nf_phase));

   int n_chk = 0, n_fail = 0, cyc = 0;
   int n_out = 0, nf_n = 0;
   int o_t [64];
   int o_d [64];
   int o_p [64];
   int nf_t [64];

   // Monitor: sample away from the active edge
   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (!rst && m_tvalid && n_out < 64) begin
         o_t[n_out] = cyc; o_d[n_out] = int'(m_tdata); o_p[n_out] = int'(m_phase);
         n_out = n_out + 1;
      end
      if (!rst && nf_mvalid && nf_n < 64) begin
         nf_t[nf_n] = cyc;
         nf_n = nf_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset(input int period);
      @(negedge clk);
      cfg_period = 8'(period);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      n_out = 0; nf_n = 0;
      rst = 1'b0;
   endtask

   task automatic feed(input int n, input int gap, input int base);
      int now = 0;
      for (int k = 0; k < n; k++) begin
         while (now < k * gap) begin @(negedge clk); now++; end
         s_tvalid = 1'b1;
         s_tdata  = 16'(base + k);
         begin
            bit acc;
            do begin
               acc = s_tready;
               @(negedge clk); now++;
            end while (!acc);
         end
         s_tvalid = 1'b0;
      end
   endtask

   function automatic int in_ofs(input int ph);
      case (ph)
         0, 1:    return 0;
         2, 3:    return 1;
         default: return 2;
      endcase
   endfunction

   // Vector table: {period, upstream gap, inputs}
   localparam int NV = 9;
   localparam logic [23:0] VEC [NV] = '{
      {8'd4, 8'd4, 8'd9},    // nominal rate, remainder-free
      {8'd3, 8'd3, 8'd9},    // nominal rate, rounded-down spacing
      {8'd4, 8'd1, 8'd12},   // burst
      {8'd5, 8'd5, 8'd9},
      {8'd6, 8'd2, 8'd9},    // upstream faster than pacer
      {8'd7, 8'd7, 8'd6},
      {8'd2, 8'd1, 8'd9},
      {8'd1, 8'd1, 8'd6},    // R9
      {8'd0, 8'd1, 8'd6}     // R9
   };

   initial begin
      // ---------------- table walk ----------------
      for (int v = 0; v < NV; v++) begin
         int p, gap, n, spc, bad, first_a, first_e;
         p = int'(VEC[v][23:16]); gap = int'(VEC[v][15:8]); n = int'(VEC[v][7:0]);
         spc = (p / 2 < 1) ? 1 : p / 2;
         do_reset(p);
         feed(n, gap, 256 * (v + 1));
         repeat (100) @(negedge clk);
         chk(n_out == n * 5 / 3, "R1", "output count", n_out, n * 5 / 3);
         bad = 0; first_a = 0; first_e = 0;
         for (int j = 0; j < n_out; j++) begin
            int ed;
            ed = 256 * (v + 1) + 3 * (j / 5) + in_ofs(j % 5);
            if (o_p[j] != j % 5 || o_d[j] != ed) begin
               if (bad == 0) begin first_a = o_d[j]; first_e = ed; end
               bad++;
            end
         end
         chk(bad == 0, "R1", "phase/data sequence (first bad data)", first_a, first_e);
         if (3 * gap < 5 * spc) begin
            bad = 0;
            for (int j = 1; j < n_out; j++)
               if (o_t[j] - o_t[j-1] != spc) begin bad++; first_a = o_t[j] - o_t[j-1]; end
            chk(bad == 0, (p < 2) ? "R9" : "R2", "backlogged spacing", first_a, spc);
         end else begin
            bad = 0;
            for (int j = 1; j < n_out; j++)
               if (o_t[j] - o_t[j-1] < spc) begin bad++; first_a = o_t[j] - o_t[j-1]; end
            chk(bad == 0, "R2", "minimum spacing", first_a, spc);
            bad = 0;
            for (int j = 0; j + 5 < n_out; j++)
               if (o_t[j+5] - o_t[j] != 3 * gap) begin bad++; first_a = o_t[j+5] - o_t[j]; end
            chk(bad == 0, "R3", "five-output span", first_a, 3 * gap);
         end
      end

      // ---------------- R7/R6: reset state, stall with no input ----------------
      do_reset(4);
      chk(m_tvalid == 1'b0, "R7", "m_tvalid after reset", int'(m_tvalid), 0);
      chk(m_phase == 3'd0, "R7", "m_phase after reset", int'(m_phase), 0);
      chk(s_tready == 1'b1, "R7", "s_tready after reset", int'(s_tready), 1);
      repeat (30) @(negedge clk);
      chk(n_out == 0, "R6", "outputs with no input", n_out, 0);

      // ---------------- R6/R7: partial group, then reset mid-group ----------------
      feed(2, 4, 16'h300);
      repeat (40) @(negedge clk);
      chk(n_out == 4, "R6", "stall after two inputs", n_out, 4);
      chk(o_p[3] == 3, "R6", "last phase before stall", o_p[3], 3);
      do_reset(4);
      feed(3, 4, 16'h400);
      repeat (40) @(negedge clk);
      chk(n_out == 5, "R7", "outputs after mid-group reset", n_out, 5);
      chk(o_p[0] == 0, "R7", "first phase after reset", o_p[0], 0);

      // ---------------- R8: period change after reset has no effect ----------------
      do_reset(4);
      cfg_period = 8'd20;
      feed(6, 1, 16'h500);
      repeat (60) @(negedge clk);
      chk(n_out == 10, "R8", "output count", n_out, 10);
      begin
         int bad = 0, a = 0;
         for (int j = 1; j < n_out; j++)
            if (o_t[j] - o_t[j-1] != 2) begin bad++; a = o_t[j] - o_t[j-1]; end
         chk(bad == 0, "R8", "spacing kept from reset value", a, 2);
      end

      // ---------------- R5: FIFO fills behind a slow pacer ----------------
      do_reset(40);
      begin
         int acc = 0;
         for (int i = 0; i < 10; i++) begin
            s_tvalid = 1'b1; s_tdata = 16'(16'h600 + acc);
            if (s_tready) acc++;
            @(negedge clk);
         end
         s_tvalid = 1'b0;
         chk(acc == 5, "R5", "inputs accepted before full", acc, 5);
         chk(s_tready == 1'b0, "R5", "s_tready when full", int'(s_tready), 0);
      end

      // ---------------- R4: direct variant, ready at the faster rate ----------------
      for (int pp = 3; pp <= 4; pp++) begin
         int bad = 0, a = 0;
         do_reset(pp);
         nf_valid = 1'b1;
         repeat (40) @(negedge clk);
         nf_valid = 1'b0;
         chk(nf_n >= 10, "R4", "direct variant output count", nf_n, 10);
         for (int j = 1; j < nf_n; j++)
            if (nf_t[j] - nf_t[j-1] != pp / 2) begin bad++; a = nf_t[j] - nf_t[j-1]; end
         chk(bad == 0, "R4", "direct variant back-to-back spacing", a, pp / 2);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule